// File: doc/BRIEF.md
# Board Net Interconnect Test Sequencer

This block runs an interconnect test across a set of board nets. Each active net gets a code word of its own, and the code words are applied one bit position per step. In each step the block presents a parallel drive vector with one bit per net. It also samples the bits that the receiving ends captured. When the last step is done, it compares every net's received word with the word it was given. From that comparison it marks the net as open, as suspected of a short, or as good.

A net with index i gets the binary value i+1 as its code. The code width is the smallest width that holds MAX_NETS+2 values, so a code is never all zeros or all ones. After the code bits, one more step drives the inverse of the code's lowest bit. This extra step separates more short cases from opens. An open net is taken to read 0. A short is taken to read the AND of the values driven on the shorted nets. The caller pulses a start input and gives a net count. The caller then waits for the done output, and the flags stay stable until the next start.

Top module: `net_code_tester`

## Requirements
- R1: While reset is high and after it is released, drive, test_active, done, open_flag and short_flag are all zero.
- R2: A start pulse begins a run one cycle later. test_active is then high for exactly CW+1 cycles, where CW = clog2(MAX_NETS+2). In active cycle k (k < CW), drive bit i equals bit k of the binary value i+1 for every net i below the net count. drive is zero whenever test_active is low.
- R3: In active cycle CW, the last one, drive bit i of every counted net equals the inverse of bit 0 of i+1.
- R4: The words driven over a run differ between any two counted nets. The code part of a word, bits 0 to CW-1, is never all zeros or all ones.
- R5: done rises in the cycle after test_active falls and is low while test_active is high. Without a new start, done, open_flag and short_flag hold their values whatever resp does.
- R6: If a counted net's received word is all zeros, its open_flag bit is set and its short_flag bit is clear.
- R7: A counted net whose received word is non-zero, differs from its own word, and equals the bitwise AND of its own word and the word of some other counted net gets its short_flag bit set. A net that receives exactly its own word is not flagged, even when it is shorted.
- R8: If every net receives its own word, both flag vectors are zero at done.
- R9: In the cycle after a start is sampled, done and both flag vectors are zero and test_active is high. This holds even when the previous run had set flags.
- R10: A net at or above the net count drives 0 in every step and is never flagged. A net count above MAX_NETS is treated as MAX_NETS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins (or restarts) a run |
| num_nets | input | clog2(MAX_NETS+1) | Number of nets under test, sampled with start |
| resp | input | MAX_NETS | Bits captured at the receiving ends during the current step |
| drive | output | MAX_NETS | Registered drive vector for the current step |
| test_active | output | 1 | High during the CW+1 drive steps |
| done | output | 1 | Result valid; held until the next start |
| open_flag | output | MAX_NETS | Per-net open result |
| short_flag | output | MAX_NETS | Per-net suspected-short result |

## Verification
The case that is hardest to produce is a short in which one partner's word dominates the other. Nets 3 and 5 have the words 1100 and 1110, and their AND equals net 3's own word. Net 5 must therefore be flagged while net 3 stays clean. The bench reaches this case with a behavioural board model. The model turns each drive vector into resp at once, applying an open mask and a group-short mask that each scenario sets before its start pulse. The same model covers opens, nets that are not counted, and the hold of the flags while resp changes.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_EVAL,
    ST_DONE
  } ntc_state_e;
endpackage

// File: rtl/ntc_pattern.sv
// Per-net drive bit for a given step: code bits first, then the inverted LSB.
module ntc_pattern #(
  parameter int MAX_NETS = 6,
  parameter int CW       = $clog2(MAX_NETS + 2),
  parameter int TS       = CW + 1,
  parameter int SW       = $clog2(TS),
  parameter int NCW      = $clog2(MAX_NETS + 1)
) (
  input  logic [SW-1:0]       step,
  input  logic [NCW-1:0]      n,
  output logic [MAX_NETS-1:0] vec
);
  function automatic logic [TS-1:0] word_of(input int idx);
    logic [CW-1:0] c;
    c = CW'(idx + 1);
    return {~c[0], c};
  endfunction

  for (genvar g = 0; g < MAX_NETS; g++) begin : g_net
    localparam logic [TS-1:0]  W   = word_of(g);
    localparam logic [NCW-1:0] IDX = NCW'(g);
    assign vec[g] = (IDX < n) ? W[step] : 1'b0;
  end
endmodule

// File: rtl/ntc_judge.sv
// Classifies each net's received word as open, suspected short, or good.
module ntc_judge #(
  parameter int MAX_NETS = 6,
  parameter int CW       = $clog2(MAX_NETS + 2),
  parameter int TS       = CW + 1,
  parameter int NCW      = $clog2(MAX_NETS + 1)
) (
  input  logic [MAX_NETS-1:0][TS-1:0] cap,
  input  logic [NCW-1:0]              n,
  output logic [MAX_NETS-1:0]         open_v,
  output logic [MAX_NETS-1:0]         short_v
);
  function automatic logic [TS-1:0] word_of(input int idx);
    logic [CW-1:0] c;
    c = CW'(idx + 1);
    return {~c[0], c};
  endfunction

  for (genvar g = 0; g < MAX_NETS; g++) begin : g_net
    localparam logic [TS-1:0]  OWN = word_of(g);
    localparam logic [NCW-1:0] IDX = NCW'(g);
    logic pair_hit, is_zero, counted;
    always_comb begin
      pair_hit = 1'b0;
      for (int j = 0; j < MAX_NETS; j++) begin
        if (j != g && NCW'(j) < n && cap[g] == (OWN & word_of(j)))
          pair_hit = 1'b1;
      end
      is_zero    = (cap[g] == '0);
      counted    = (IDX < n);
      open_v[g]  = counted && is_zero;
      short_v[g] = counted && !is_zero && (cap[g] != OWN) && pair_hit;
    end
  end
endmodule

// File: rtl/net_code_tester.sv
module net_code_tester #(
  parameter int MAX_NETS = 6,
  localparam int CW      = $clog2(MAX_NETS + 2),
  localparam int TS      = CW + 1,
  localparam int SW      = $clog2(TS),
  localparam int NCW     = $clog2(MAX_NETS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [NCW-1:0]      num_nets,
  input  logic [MAX_NETS-1:0] resp,
  output logic [MAX_NETS-1:0] drive,
  output logic                test_active,
  output logic                done,
  output logic [MAX_NETS-1:0] open_flag,
  output logic [MAX_NETS-1:0] short_flag
);
  import ntc_pkg::*;

  ntc_state_e                  state_q;
  logic [SW-1:0]               step_q;
  logic [NCW-1:0]              n_q;
  logic [MAX_NETS-1:0][TS-1:0] cap_q;
  logic [NCW-1:0]              n_clamp, pat_n;
  logic [SW-1:0]               pat_step;
  logic [MAX_NETS-1:0]         pat_vec, open_v, short_v;

  assign n_clamp  = (num_nets > NCW'(MAX_NETS)) ? NCW'(MAX_NETS) : num_nets;
  assign pat_n    = start ? n_clamp : n_q;
  assign pat_step = start ? '0 : step_q + SW'(1);

  ntc_pattern #(.MAX_NETS(MAX_NETS), .CW(CW), .TS(TS), .SW(SW), .NCW(NCW)) u_pattern (
    .step (pat_step),
    .n    (pat_n),
    .vec  (pat_vec)
  );

  ntc_judge #(.MAX_NETS(MAX_NETS), .CW(CW), .TS(TS), .NCW(NCW)) u_judge (
    .cap     (cap_q),
    .n       (n_q),
    .open_v  (open_v),
    .short_v (short_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      step_q      <= '0;
      n_q         <= '0;
      cap_q       <= '0;
      drive       <= '0;
      test_active <= 1'b0;
      done        <= 1'b0;
      open_flag   <= '0;
      short_flag  <= '0;
    end else if (start) begin
      state_q     <= ST_RUN;
      step_q      <= '0;
      n_q         <= n_clamp;
      cap_q       <= '0;
      drive       <= pat_vec;
      test_active <= 1'b1;
      done        <= 1'b0;
      open_flag   <= '0;
      short_flag  <= '0;
    end else begin
      case (state_q)
        ST_RUN: begin
          for (int i = 0; i < MAX_NETS; i++) cap_q[i][step_q] <= resp[i];
          if (step_q == SW'(TS - 1)) begin
            state_q     <= ST_EVAL;
            drive       <= '0;
            test_active <= 1'b0;
          end else begin
            step_q <= step_q + SW'(1);
            drive  <= pat_vec;
          end
        end
        ST_EVAL: begin
          open_flag  <= open_v;
          short_flag <= short_v;
          done       <= 1'b1;
          state_q    <= ST_DONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ntc_checker.sv
module ntc_checker #(
  parameter int MAX_NETS = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic [MAX_NETS-1:0] drive,
  input logic                test_active,
  input logic                done,
  input logic [MAX_NETS-1:0] open_flag,
  input logic [MAX_NETS-1:0] short_flag
);
  AST_IDLE_DRIVE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !test_active |-> drive == '0); // R2

  AST_DONE_FOLLOWS_RUN: assert property (@(posedge clk) disable iff (rst)
    ($fell(test_active) && !start) |=> done); // R5

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(open_flag) && $stable(short_flag))); // R5

  AST_ACTIVE_EXCLUDES_DONE: assert property (@(posedge clk) disable iff (rst)
    test_active |-> !done); // R5

  AST_OPEN_SHORT_EXCL: assert property (@(posedge clk) disable iff (rst)
    (open_flag & short_flag) == '0); // R6

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (test_active && !done && open_flag == '0 && short_flag == '0)); // R9
endmodule

bind net_code_tester ntc_checker #(.MAX_NETS(MAX_NETS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .drive       (drive),
  .test_active (test_active),
  .done        (done),
  .open_flag   (open_flag),
  .short_flag  (short_flag)
);

// File: tb/tb_net_code_tester.sv
module tb_net_code_tester;
  localparam int MAX_NETS = 6;
  localparam int CW       = 3;
  localparam int TS       = 4;
  localparam int NCW      = 3;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                start = 1'b0;
  logic [NCW-1:0]      num_nets = '0;
  logic [MAX_NETS-1:0] resp;
  logic [MAX_NETS-1:0] drive;
  logic                test_active, done;
  logic [MAX_NETS-1:0] open_flag, short_flag;

  logic [MAX_NETS-1:0] open_m = '0;
  logic [MAX_NETS-1:0] short_m = '0;
  logic [TS-1:0]       words [MAX_NETS];
  int                  checks = 0;
  int                  errors = 0;

  always #2 clk = ~clk;

  net_code_tester #(.MAX_NETS(MAX_NETS)) dut (
    .clk(clk), .rst(rst), .start(start), .num_nets(num_nets), .resp(resp),
    .drive(drive), .test_active(test_active), .done(done),
    .open_flag(open_flag), .short_flag(short_flag)
  );

  // Board model: opens read 0, the short group reads the AND of its drivers.
  always_comb begin
    for (int i = 0; i < MAX_NETS; i++)
      resp[i] = open_m[i] ? 1'b0 : (short_m[i] ? &(drive | ~short_m) : drive[i]);
  end

  function automatic logic [TS-1:0] exp_word(input int idx);
    logic [CW-1:0] c;
    c = CW'(idx + 1);
    return {~c[0], c};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_case(input logic [NCW-1:0] n_in, input int n_eff,
                          input logic [MAX_NETS-1:0] om, input logic [MAX_NETS-1:0] sm,
                          input logic [MAX_NETS-1:0] exp_o, input logic [MAX_NETS-1:0] exp_s,
                          input string tag);
    int cnt;
    open_m  = om;
    short_m = sm;
    @(negedge clk); start = 1'b1; num_nets = n_in;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < MAX_NETS; i++) words[i] = '0;
    cnt = 0;
    while (test_active && cnt < 16) begin
      if (cnt < TS) for (int i = 0; i < MAX_NETS; i++) words[i][cnt] = drive[i];
      cnt++;
      @(negedge clk);
    end
    chk(cnt == TS, {"R2 active length ", tag}, cnt, TS);
    chk(done == 1'b0, {"R5 done low right after run ", tag}, done, 0);
    @(negedge clk);
    chk(done == 1'b1, {"R5 done one cycle after run ", tag}, done, 1);
    for (int i = 0; i < MAX_NETS; i++) begin
      logic [TS-1:0] e;
      e = (i < n_eff) ? exp_word(i) : '0;
      chk(words[i] == e, {"R2 R3 R10 driven word ", tag}, words[i], e);
    end
    chk(open_flag == exp_o, {"R6 R10 open flags ", tag}, open_flag, exp_o);
    chk(short_flag == exp_s, {"R7 R8 short flags ", tag}, short_flag, exp_s);
  endtask

  task automatic check_codes();
    for (int i = 0; i < MAX_NETS; i++) begin
      chk(words[i][CW-1:0] != '0 && words[i][CW-1:0] != '1, "R4 code not all0/all1",
          words[i], 0);
      for (int j = i + 1; j < MAX_NETS; j++)
        chk(words[i] != words[j], "R4 words distinct", words[i], words[j]);
    end
  endtask

  task automatic hold_and_restart();
    logic [MAX_NETS-1:0] o_prev, s_prev;
    o_prev = open_flag;
    s_prev = short_flag;
    open_m  = '0;
    short_m = 6'b000011;
    repeat (5) @(negedge clk);
    chk(done && open_flag == o_prev && short_flag == s_prev, "R5 flags held",
        {open_flag, short_flag}, {o_prev, s_prev});
    start = 1'b1; num_nets = 3'd6;
    @(negedge clk); start = 1'b0;
    chk(!done && open_flag == '0 && short_flag == '0 && test_active, "R9 start clears",
        {done, open_flag, short_flag, test_active}, 1);
    for (int k = 0; k < 16 && !done; k++) @(negedge clk);
  endtask

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(drive == '0 && !test_active && !done && open_flag == '0 && short_flag == '0,
        "R1 reset state", {drive, test_active, done, open_flag, short_flag}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(drive == '0 && !test_active && !done, "R1 after release", {drive, test_active, done}, 0);
    run_case(3'd6, 6, '0, '0, '0, '0, "fault free");          // R8
    check_codes();                                            // R4
    run_case(3'd6, 6, 6'b000100, '0, 6'b000100, '0, "open net2");  // R6
    run_case(3'd6, 6, '0, 6'b000110, '0, 6'b000110, "short 1-2");  // R7
    run_case(3'd6, 6, '0, 6'b101000, '0, 6'b100000, "short 3-5");  // R7 dominant partner
    run_case(3'd3, 3, 6'b010000, '0, '0, '0, "count 3");           // R10
    run_case(3'd7, 6, '0, '0, '0, '0, "count clamp");              // R10
    run_case(3'd6, 6, 6'b000100, '0, 6'b000100, '0, "open before hold");
    hold_and_restart();                                       // R5 R9
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule